// File: doc/BRIEF.md
# Carrier Sense and Collision Generator

This block drives the carrier-sense and collision indications of a media-independent interface. It takes the local transmit enable, a receive activity source, and the link configuration: half or full duplex, repeater or node role, and 10 or 100 Mbps. From these it forms `crs` and `col`. Both outputs follow their inputs without a clock stage. State is kept only where time matters.

Receive activity comes from one of two places. At 100 Mbps a small detector watches the recovered serial code bits, one bit per clock. It raises carrier on a pair of separated zeros and drops it after a long run of ones. At 10 Mbps an external squelch signal is used as it is.

In 10 Mbps node operation, `col` also carries the signal-quality-error test pulse. This pulse appears a set time after each transmission ends. It can be turned off with an inhibit input.

Top module: `crs_col_gen`

## Requirements
- R1: In half duplex node mode, `crs` is 1 when `tx_en` is 1 or receive carrier is present, and 0 only when both are absent.
- R2: With `fdx`=1 or `rpt`=1, `crs` equals receive carrier and ignores `tx_en`.
- R3: With `fdx`=0, `col` is 1 whenever receive carrier and `tx_en` are both 1.
- R4: With `fdx`=1, `col` is 0 at all times, whatever the other inputs are.
- R5: With `spd100`=1, `rx_bit` is a code bit per clock (0 = zero, 1 = one). Carrier rises one clock after a zero is sampled, but only if the previous zero came 1 to 8 ones earlier, so that the two zeros are non-adjacent and within a 10-bit window. Adjacent zeros do not start carrier, and neither do zeros 9 or more ones apart.
- R6: Once carrier is up at 100 Mbps, it stays up until `IDLE_ONES` (default 10) consecutive ones are sampled. It drops one clock after the last of them.
- R7: With `spd100`=0, receive carrier equals `rx_sq` combinationally.
- R8: With `spd100`=0, `fdx`=0, `rpt`=0 and `sqe_inh`=0, the clock edge that samples `tx_en` low after a high starts a wait. `col` then goes high `SQE_DLY` (default 16) clocks after that edge and stays high for exactly `SQE_LEN` (default 10) clocks.
- R9: No test pulse is produced, and any pending pulse is cancelled, while `sqe_inh`, `rpt`, `spd100` or `fdx` is 1.
- R10: `tx_en` rising cancels a pending or running test pulse. `col` shows no test pulse from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the 100 Mbps code bit rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Local transmit enable |
| fdx | input | 1 | 1 = full duplex |
| rpt | input | 1 | 1 = repeater role |
| spd100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| sqe_inh | input | 1 | 1 = suppress the test pulse |
| rx_bit | input | 1 | Recovered serial code bit (100 Mbps) |
| rx_sq | input | 1 | Unsquelched receive activity (10 Mbps) |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision / test pulse |

## Verification
The bench sends zeros at distances of 1, 2, 9 and 10 bits. A detector with an off-by-one window would raise carrier on adjacent zeros or on zeros a full 10 bits apart, or would miss the 9-bit case. It also counts ones down to the idle threshold, where a detector off by one would drop carrier a bit early or late. The test pulse is measured clock by clock for its start and width. The bench then checks that every inhibiting mode gives silence and that a mid-pulse `tx_en` rise cuts the pulse off; a loose state machine would leak a pulse or finish it anyway. The mode tests catch a transmit term that leaks into `crs` in full duplex or repeater mode, and any `col` in full duplex.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_PULSE} sqe_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/csc_zero_pair_det.sv
module csc_zero_pair_det #(
  parameter int WIN_BITS  = 10,
  parameter int IDLE_ONES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  output logic active
);
  import csc_pkg::*;

  localparam int SAT  = imax(WIN_BITS, IDLE_ONES);
  localparam int RW   = $clog2(SAT + 1);
  localparam int GAPX = WIN_BITS - 2;

  logic [RW-1:0] run_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= RW'(SAT);
      act_q <= 1'b0;
    end else if (rx_bit) begin
      if (run_q != RW'(SAT)) run_q <= run_q + 1'b1;
      if (act_q && (int'(run_q) + 1 >= IDLE_ONES)) act_q <= 1'b0;
    end else begin
      run_q <= '0;
      if (run_q >= RW'(1) && run_q <= RW'(GAPX)) act_q <= 1'b1;
    end
  end

  assign active = act_q;

  logic [RW-1:0] chk_ones;
  always_ff @(posedge clk) begin
    if (rst) chk_ones <= RW'(SAT);
    else if (!rx_bit) chk_ones <= '0;
    else if (chk_ones != RW'(SAT)) chk_ones <= chk_ones + 1'b1;
  end

  assert_ones_never_start_R5: assert property (@(posedge clk) disable iff (rst)
    (!act_q && rx_bit) |=> !act_q);
  assert_idle_after_run_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(chk_ones) >= IDLE_ONES) |-> !act_q);
endmodule

// File: rtl/csc_sqe_gen.sv
module csc_sqe_gen #(
  parameter int SQE_DLY = 16,
  parameter int SQE_LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic en,
  output logic sqe
);
  import csc_pkg::*;

  localparam int CW = $clog2(imax(SQE_DLY, SQE_LEN) + 1);

  sqe_state_t    st;
  logic [CW-1:0] cnt;
  logic          tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_IDLE;
      cnt  <= '0;
      tx_q <= 1'b0;
    end else begin
      tx_q <= tx_en;
      if (!en || tx_en) begin
        st  <= SQ_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          SQ_IDLE: if (tx_q) begin
            st  <= SQ_WAIT;
            cnt <= '0;
          end
          SQ_WAIT: if (cnt == CW'(SQE_DLY - 1)) begin
            st  <= SQ_PULSE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
          SQ_PULSE: if (cnt == CW'(SQE_LEN - 1)) begin
            st  <= SQ_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end

  assign sqe = (st == SQ_PULSE);

  logic [CW-1:0] chk_run;
  always_ff @(posedge clk) begin
    if (rst) chk_run <= '0;
    else if (sqe) chk_run <= chk_run + 1'b1;
    else chk_run <= '0;
  end

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (rst)
    sqe |-> (int'(chk_run) < SQE_LEN));
  assert_off_no_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sqe);
  assert_tx_abort_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |=> !sqe);
endmodule

// File: rtl/crs_col_gen.sv
module crs_col_gen #(
  parameter int WIN_BITS  = 10,
  parameter int IDLE_ONES = 10,
  parameter int SQE_DLY   = 16,
  parameter int SQE_LEN   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic fdx,
  input  logic rpt,
  input  logic spd100,
  input  logic sqe_inh,
  input  logic rx_bit,
  input  logic rx_sq,
  output logic crs,
  output logic col
);
  logic det_act;
  logic rx_car;
  logic sqe_en;
  logic sqe;
  logic tx_counts;

  csc_zero_pair_det #(.WIN_BITS(WIN_BITS), .IDLE_ONES(IDLE_ONES)) u_det (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .active(det_act)
  );

  assign sqe_en = !spd100 && !fdx && !rpt && !sqe_inh;

  csc_sqe_gen #(.SQE_DLY(SQE_DLY), .SQE_LEN(SQE_LEN)) u_sqe (
    .clk(clk), .rst(rst), .tx_en(tx_en), .en(sqe_en), .sqe(sqe)
  );

  always_comb begin
    rx_car    = spd100 ? det_act : rx_sq;
    tx_counts = !fdx && !rpt;
    crs       = rx_car || (tx_counts && tx_en);
    col       = !fdx && ((rx_car && tx_en) || sqe);
  end

  assert_hdx_tx_crs_R1: assert property (@(posedge clk) disable iff (rst)
    (!fdx && !rpt && tx_en) |-> crs);
  assert_rx_gives_crs_R2: assert property (@(posedge clk) disable iff (rst)
    (spd100 && det_act) |-> crs);
  assert_fdx_col_low_R4: assert property (@(posedge clk) disable iff (rst)
    fdx |-> !col);
endmodule

// File: tb/crs_col_gen_bench.sv
module crs_col_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, fdx = 1'b0, rpt = 1'b0, spd100 = 1'b0, sqe_inh = 1'b1;
  logic rx_bit = 1'b1, rx_sq = 1'b0;
  logic crs, col;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crs_col_gen u_crs_col_gen (
    .clk(clk), .rst(rst), .tx_en(tx_en), .fdx(fdx), .rpt(rpt),
    .spd100(spd100), .sqe_inh(sqe_inh), .rx_bit(rx_bit), .rx_sq(rx_sq),
    .crs(crs), .col(col)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    tx_en = 0; rx_bit = 1; rx_sq = 0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b;
    @(negedge clk);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic t_reset();
    fdx = 0; rpt = 0; spd100 = 1; sqe_inh = 1;
    do_reset();
    check("R5", "crs after reset", crs, 0);
    check("R3", "col after reset", col, 0);
  endtask

  task automatic t_modes();
    fdx = 0; rpt = 0; spd100 = 0; sqe_inh = 1;
    do_reset();
    tx_en = 1; rx_sq = 0; #1;
    check("R1", "hdx crs tx only", crs, 1);
    check("R3", "hdx col tx only", col, 0);
    tx_en = 0; rx_sq = 1; #1;
    check("R1", "hdx crs rx only", crs, 1);
    check("R7", "10M carrier from rx_sq", crs, 1);
    rx_sq = 0; #1;
    check("R1", "hdx crs idle", crs, 0);
    tx_en = 1; rx_sq = 1; #1;
    check("R3", "hdx collision", col, 1);
    rpt = 1; #1;
    check("R3", "repeater collision", col, 1);
    rx_sq = 0; #1;
    check("R2", "repeater ignores tx", crs, 0);
    rpt = 0; fdx = 1; rx_sq = 1; #1;
    check("R4", "fdx col low", col, 0);
    check("R2", "fdx crs rx", crs, 1);
    rx_sq = 0; #1;
    check("R2", "fdx ignores tx", crs, 0);
    tx_en = 0; fdx = 0;
    @(negedge clk);
  endtask

  task automatic t_detect();
    fdx = 1; rpt = 0; spd100 = 1; sqe_inh = 1;
    do_reset();
    send_ones(12);
    send_bit(0); send_bit(0);
    check("R5", "adjacent zeros", crs, 0);
    send_ones(12);
    send_bit(0); send_ones(9); send_bit(0);
    check("R5", "zeros 10 apart", crs, 0);
    send_ones(12);
    send_bit(0); send_ones(8);
    check("R5", "single zero", crs, 0);
    send_bit(0);
    check("R5", "zeros 9 apart", crs, 1);
    send_ones(9);
    check("R6", "still active after 9 ones", crs, 1);
    send_bit(1);
    check("R6", "idle after 10 ones", crs, 0);
    send_bit(0); send_bit(1); send_bit(0);
    check("R5", "zeros 2 apart", crs, 1);
    tx_en = 1; #1;
    check("R4", "fdx col with carrier", col, 0);
    fdx = 0; #1;
    check("R3", "100M collision", col, 1);
    tx_en = 0; fdx = 1;
    send_ones(10);
    check("R6", "idle again", crs, 0);
  endtask

  task automatic measure(input string req, input int exp_first, input int exp_cnt);
    int first = 0;
    int cnt = 0;
    tx_en = 1;
    repeat (3) @(negedge clk);
    tx_en = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (col) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    check(req, "pulse start", first, exp_first);
    check(req, "pulse width", cnt, exp_cnt);
  endtask

  task automatic t_sqe();
    fdx = 0; rpt = 0; spd100 = 0; sqe_inh = 0;
    do_reset();
    measure("R8", 17, 10);
    sqe_inh = 1; measure("R9", 0, 0);
    sqe_inh = 0; rpt = 1; measure("R9", 0, 0);
    rpt = 0; spd100 = 1; measure("R9", 0, 0);
    spd100 = 0; fdx = 1; measure("R9", 0, 0);
    fdx = 0;
  endtask

  task automatic t_abort();
    int seen = 0;
    fdx = 0; rpt = 0; spd100 = 0; sqe_inh = 0;
    do_reset();
    tx_en = 1; repeat (3) @(negedge clk);
    tx_en = 0;
    repeat (17) @(negedge clk);
    check("R8", "pulse running", col, 1);
    tx_en = 1;
    @(negedge clk);
    check("R10", "abort in pulse", col, 0);
    tx_en = 0;
    repeat (10) @(negedge clk);
    tx_en = 1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (col) seen++;
    end
    check("R10", "abort in wait", seen, 0);
    tx_en = 0;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_modes();
    t_detect();
    t_sqe();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule